// File: doc/BRIEF.md
# Dual-Line Asynchronous Serial Frame Monitor

This block listens, without driving anything, to two asynchronous serial lines: channel 0 (the receive line) and channel 1 (the transmit line). Each line has its own decoder. A decoder finds the falling edge that opens a frame and confirms the start bit at its centre. It then samples each following bit at its centre and builds a data word. The word length is 5 to 9 bits, and the bits can arrive least-significant first or most-significant first. The decoder then checks an optional parity bit and a single stop bit.

The bit time is set at run time by a clocks-per-bit divisor. The data length, parity mode, bit order and divisor are captured by each decoder when it sees the start edge. A frame in flight therefore keeps the settings it began with. Each channel reports every completed frame with its own one-cycle valid pulse, the received word, a parity-error flag and a framing-error flag. The channel is identified by the bit lane of the outputs.

Top module: `serial_pair_monitor`

## Requirements
- R1: While reset is asserted, and after it is released, all valid pulses, error flags and words read zero until a frame completes.
- R2: A frame begins at a high-to-low transition of the line, seen through a two-flop synchronizer. If the line reads high again at the centre of the start bit, the decoder returns to idle and produces no valid pulse.
- R3: The word length comes from `cfg_width` and is limited to the range 5 to 9. A value below 5 is used as 5, and a value above 9 is used as 9. The word is right-aligned in the channel's 9-bit lane, and the unused upper bits are zero.
- R4: With `cfg_msb_first` = 0, the first data bit on the line is word bit 0. With `cfg_msb_first` = 1, the first data bit on the line is word bit width-1.
- R5: `cfg_parity` selects the parity mode: 0 none, 1 odd, 2 even, 3 parity bit must be 0, 4 parity bit must be 1. Codes 5 to 7 act as none. For odd and even, the count of ones over the data and the parity bit must be odd or even. `parity_err` is set when the check fails.
- R6: When parity is off, there is no parity slot. The stop bit is the bit that follows the last data bit, and `parity_err` stays 0.
- R7: A stop bit sampled low sets `stop_err` for that frame, and the word is still delivered.
- R8: Each completed frame gives exactly one single-cycle `frame_valid` pulse on its channel, with the word and both flags valid in that cycle.
- R9: Configuration is captured when the start edge is seen. Changes made while a frame is in progress do not affect that frame.
- R10: The two channels decode independently, so overlapping frames on both lines are each reported correctly.
- R11: One bit lasts `cfg_clks_per_bit` clocks (at least 4). The start bit is checked half a bit period, rounded down, after the edge is seen, and each later bit is sampled one full period after the bit before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 2 | Serial lines, bit 0 receive, bit 1 transmit; idle high |
| cfg_width | input | 4 | Data bits per frame (5..9, clamped) |
| cfg_parity | input | 3 | Parity mode code |
| cfg_msb_first | input | 1 | 1 selects most-significant-first order |
| cfg_clks_per_bit | input | 16 | Clocks per bit period |
| frame_valid | output | 2 | One-cycle pulse per frame, per channel |
| frame_word | output | 18 | Channel n word in bits [9n+8:9n] |
| parity_err | output | 2 | Parity check failed, per channel |
| stop_err | output | 2 | Stop bit sampled low, per channel |

## Verification
A decoder that enters a wrong state, or a bit counter that slips, shows up at the ports as a frame reported in the wrong place. The word appears shifted, a parity or stop flag is spurious, or the valid pulse comes one bit period early or late, missing, or doubled. All of this is visible within the frame being received. Frames are sent with an exact bit period from the bench. The bench checks the word, both flags, and that exactly one valid pulse appears on the addressed channel during the frame. It also checks that none appears for a rejected start glitch.

// File: rtl/serial_pair_monitor.sv
module serial_pair_monitor #(
  parameter int DATA_MAX = 9,
  parameter int DIV_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              ser_in,
  input  logic [3:0]              cfg_width,
  input  logic [2:0]              cfg_parity,
  input  logic                    cfg_msb_first,
  input  logic [DIV_W-1:0]        cfg_clks_per_bit,
  output logic [1:0]              frame_valid,
  output logic [2*DATA_MAX-1:0]   frame_word,
  output logic [1:0]              parity_err,
  output logic [1:0]              stop_err
);
  localparam int DATA_MIN = 5;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} st_t;

  logic [3:0] width_eff;
  logic [2:0] par_eff;
  assign width_eff = (cfg_width < 4'(DATA_MIN)) ? 4'(DATA_MIN) :
                     (cfg_width > 4'(DATA_MAX)) ? 4'(DATA_MAX) : cfg_width;
  assign par_eff   = (cfg_parity > 3'd4) ? 3'd0 : cfg_parity;

  for (genvar ch = 0; ch < 2; ch++) begin : g_lane
    st_t                 st;
    logic                s1, s2, s3;
    logic [DIV_W-1:0]    cnt, div_l;
    logic [3:0]          bits_l, idx;
    logic [2:0]          par_l;
    logic                msb_l;
    logic [DATA_MAX-1:0] sh, dat_q;
    logic                perr, vld_q, perr_q, ferr_q;
    logic                tick, ones, par_bad;
    logic [DATA_MAX-1:0] lsb_in;

    assign tick   = (cnt == '0);
    assign ones   = ^sh ^ s2;
    assign lsb_in = {{(DATA_MAX-1){1'b0}}, s2} << (bits_l - 4'd1);

    always_comb begin
      case (par_l)
        3'd1:    par_bad = ~ones;
        3'd2:    par_bad = ones;
        3'd3:    par_bad = s2;
        3'd4:    par_bad = ~s2;
        default: par_bad = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st <= ST_IDLE;
        {s1, s2, s3} <= 3'b111;
        cnt <= '0; div_l <= '0; bits_l <= 4'(DATA_MIN); idx <= '0;
        par_l <= '0; msb_l <= 1'b0; sh <= '0; perr <= 1'b0;
        dat_q <= '0; vld_q <= 1'b0; perr_q <= 1'b0; ferr_q <= 1'b0;
      end else begin
        s1 <= ser_in[ch];
        s2 <= s1;
        s3 <= s2;
        vld_q <= 1'b0;
        case (st)
          ST_IDLE: if (s3 && !s2) begin
            bits_l <= width_eff;
            par_l  <= par_eff;
            msb_l  <= cfg_msb_first;
            div_l  <= cfg_clks_per_bit;
            cnt    <= cfg_clks_per_bit >> 1;
            st     <= ST_START;
          end
          ST_START: if (tick) begin
            if (s2) st <= ST_IDLE;
            else begin
              st <= ST_DATA; cnt <= div_l - 1'b1;
              idx <= '0; sh <= '0; perr <= 1'b0;
            end
          end else cnt <= cnt - 1'b1;
          ST_DATA: if (tick) begin
            sh  <= msb_l ? {sh[DATA_MAX-2:0], s2} : ((sh >> 1) | lsb_in);
            idx <= idx + 4'd1;
            cnt <= div_l - 1'b1;
            if (idx == bits_l - 4'd1) st <= (par_l != 3'd0) ? ST_PAR : ST_STOP;
          end else cnt <= cnt - 1'b1;
          ST_PAR: if (tick) begin
            perr <= par_bad;
            cnt  <= div_l - 1'b1;
            st   <= ST_STOP;
          end else cnt <= cnt - 1'b1;
          ST_STOP: if (tick) begin
            dat_q  <= sh;
            perr_q <= perr;
            ferr_q <= ~s2;
            vld_q  <= 1'b1;
            st     <= ST_IDLE;
          end else cnt <= cnt - 1'b1;
          default: st <= ST_IDLE;
        endcase
      end
    end

    assign frame_valid[ch] = vld_q;
    assign parity_err[ch]  = perr_q;
    assign stop_err[ch]    = ferr_q;
    assign frame_word[ch*DATA_MAX +: DATA_MAX] = dat_q;

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q);
    // R6
    no_par_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && par_l == 3'd0) |-> !perr_q);
    // R3
    word_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> ((dat_q >> bits_l) == '0));
    // R11
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE) |-> (cnt < div_l));
    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && $past(st) != ST_IDLE) |->
        ($stable(bits_l) && $stable(par_l) && $stable(msb_l) && $stable(div_l)));
  end
endmodule

// File: tb/tb_serial_pair_monitor.sv
module tb_serial_pair_monitor;
  localparam int CLK_P = 10;
  localparam int W = 9;

  logic clk = 0, rst_n = 0;
  logic [1:0] ser_in = 2'b11;
  logic [3:0] cfg_width = 4'd8;
  logic [2:0] cfg_parity = 3'd0;
  logic cfg_msb_first = 0;
  logic [15:0] cfg_clks_per_bit = 16'd16;
  logic [1:0] frame_valid, parity_err, stop_err;
  logic [2*W-1:0] frame_word;
  int checks = 0, failures = 0;

  serial_pair_monitor dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_bit(input int ch, input bit v, input int cyc);
    ser_in[ch] = v;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic send(input int ch, input int d, input int nb, input int par,
                      input bit msb, input bit bad_par, input bit stop_v, input int dv);
    bit p;
    drive_bit(ch, 0, dv);
    for (int i = 0; i < nb; i++)
      drive_bit(ch, msb ? d[nb-1-i] : d[i], dv);
    if (par >= 1 && par <= 4) begin
      case (par)
        1: p = ~^(d & ((1 << nb) - 1));
        2: p = ^(d & ((1 << nb) - 1));
        3: p = 0;
        default: p = 1;
      endcase
      drive_bit(ch, p ^ bad_par, dv);
    end
    drive_bit(ch, stop_v, dv);
    drive_bit(ch, 1, 2 * dv);
  endtask

  task automatic expect_frame(input int ch, input int d, input bit pe, input bit fe,
                              input int cyc, input string req);
    int pulses = 0, got_d = 0;
    bit got_pe = 0, got_fe = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (frame_valid[ch]) begin
        pulses++;
        got_d = int'(frame_word[ch*W +: W]);
        got_pe = parity_err[ch];
        got_fe = stop_err[ch];
      end
    end
    chk(pulses == 1, req, "valid pulse count", pulses, 1);
    chk(got_d == d, req, "word", got_d, d);
    chk(got_pe == pe, req, "parity_err", got_pe, pe);
    chk(got_fe == fe, req, "stop_err", got_fe, fe);
  endtask

  task automatic frame(input int ch, input int d, input int nb, input int par,
                       input bit msb, input bit bad_par, input bit stop_v,
                       input int dv, input string req);
    int pslot = (par >= 1 && par <= 4) ? 1 : 0;
    cfg_clks_per_bit = 16'(dv);
    cfg_msb_first = msb;
    fork
      send(ch, d, nb, par, msb, bad_par, stop_v, dv);
      expect_frame(ch, d & ((1 << nb) - 1), (pslot == 1) && bad_par, !stop_v,
                   (nb + pslot + 3) * dv, req);
    join
  endtask

  task automatic t_reset;
    chk(frame_valid == 0 && parity_err == 0 && stop_err == 0, "R1", "flags in reset",
        {frame_valid, parity_err, stop_err}, 0);
    @(negedge clk); rst_n = 1;
    repeat (5) @(negedge clk);
    chk(frame_word == 0 && frame_valid == 0, "R1", "outputs after reset",
        int'(frame_word), 0);
  endtask

  task automatic t_basic;
    cfg_width = 8; cfg_parity = 0;
    frame(0, 8'hA5, 8, 0, 0, 0, 1, 16, "R4_R11 lsb 8N");
    cfg_width = 9; cfg_parity = 2;
    frame(0, 9'h1C3, 9, 2, 1, 0, 1, 16, "R3_R4_R5 msb 9E");
  endtask

  task automatic t_parity;
    cfg_width = 7; cfg_parity = 1;
    frame(1, 7'h35, 7, 1, 0, 1, 1, 12, "R5 odd bad");
    frame(1, 7'h34, 7, 1, 0, 0, 1, 12, "R5 odd good");
    cfg_parity = 3;
    frame(0, 7'h7F, 7, 3, 0, 0, 1, 12, "R5 zero good");
    cfg_parity = 4;
    frame(0, 7'h01, 7, 4, 1, 1, 1, 12, "R5 one bad");
    cfg_width = 6; cfg_parity = 6;
    frame(0, 6'h2B, 6, 0, 0, 0, 1, 12, "R5 code6 as none");
  endtask

  task automatic t_short_nopar;
    cfg_width = 5; cfg_parity = 0;
    frame(1, 5'h13, 5, 0, 1, 0, 1, 9, "R3_R6 5N div9");
  endtask

  task automatic t_stop;
    cfg_width = 8; cfg_parity = 2;
    frame(0, 8'h5A, 8, 2, 0, 0, 0, 16, "R7 low stop");
  endtask

  task automatic t_glitch;
    int pulses = 0;
    cfg_clks_per_bit = 16;
    ser_in[0] = 0;
    repeat (3) @(negedge clk);
    ser_in[0] = 1;
    for (int i = 0; i < 16 * 14; i++) begin
      @(negedge clk);
      if (frame_valid[0]) pulses++;
    end
    chk(pulses == 0, "R2", "pulse after rejected start", pulses, 0);
  endtask

  task automatic t_cfg_change;
    cfg_width = 8; cfg_parity = 0;
    fork
      frame(0, 8'hC6, 8, 0, 0, 0, 1, 16, "R9 mid-frame cfg");
      begin
        repeat (48) @(negedge clk);
        cfg_width = 5; cfg_parity = 1; cfg_clks_per_bit = 20;
      end
    join
  endtask

  task automatic t_dual;
    cfg_width = 8; cfg_parity = 2; cfg_clks_per_bit = 16; cfg_msb_first = 0;
    fork
      send(0, 8'h3C, 8, 2, 0, 0, 1, 16);
      begin repeat (37) @(negedge clk); send(1, 8'hE1, 8, 2, 0, 1, 1, 16); end
      expect_frame(0, 8'h3C, 0, 0, 11 * 16, "R10 ch0");
      begin repeat (37) @(negedge clk); expect_frame(1, 8'hE1, 1, 0, 11 * 16, "R10 ch1"); end
    join
  endtask

  task automatic t_clamp;
    cfg_width = 3; cfg_parity = 0;
    frame(1, 5'h1D, 5, 0, 0, 0, 1, 10, "R3 width 3 clamps to 5");
    cfg_width = 13;
    frame(1, 9'h155, 9, 0, 1, 0, 1, 10, "R3 width 13 clamps to 9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_short_nopar();
    t_stop();
    t_glitch();
    t_cfg_change();
    t_dual();
    t_clamp();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule